// File: doc/BRIEF.md
# Zoned Fully Associative Route Result Cache

This block keeps recent forwarding decisions close to the datapath. It maps a 32-bit IPv4 destination address to a 10-bit outbound interface number. Its storage is divided into one to four zones. Each zone is fully associative and is sized by its own parameter. Each zone owns a contiguous band of route prefix lengths, and the bands run in increasing order and together cover every length from 0 to 32.

A lookup searches every valid line of every zone in the same cycle and answers one cycle later with hit or miss and the stored interface. A fill carries the result of a slow-path route search: the address, the interface and the prefix length of the matched route. The prefix length picks the zone that receives a new entry. An address already held anywhere is rewritten in place instead. A full zone gives up its least recently used line. Per-zone hit counters and a global miss counter let an outside model compare hit rates.

Top module: `zoned_addr_cache`

## Requirements
- R1: A lookup presented with `lk_valid` high at a clock edge produces `rsp_valid` high after that same edge, for exactly one cycle. `rsp_hit` and `rsp_port` give the stored 10-bit interface on a hit. On a miss, `rsp_port` is 0.
- R2: A new address from a fill goes into the zone whose band holds `fl_plen`. Zone 0 takes lengths up to `ZB0`, zone z takes lengths above boundary z-1 up to boundary z, and the last zone takes everything above its lower boundary, including values above 32. With the defaults, lengths 0..22 go to zone 0 and 23..63 go to zone 1.
- R3: While a zone has an invalid line, a new fill into that zone takes an invalid line and evicts nothing, so a zone of L lines holds L distinct addresses.
- R4: An address is held at most once in the whole cache. A fill for an address that is already present rewrites that entry's interface in its current zone, whatever `fl_plen` says, and uses no new line.
- R5: A new fill into a full zone replaces that zone's least recently used line. Recency is refreshed by lookup hits, by in-place rewrites and by new fills. If a fill touches a zone in the same cycle as a lookup hit in that zone, only the fill's line is refreshed.
- R6: After reset every line is invalid. `inv_all` clears every line at the next edge, and a fill in the same cycle is dropped.
- R7: A lookup and a fill in the same cycle see the cache as it was before the fill. A lookup for the address being filled therefore reports the old state.
- R8: `hit_cnt` packs one CNT_W-bit counter per zone, with zone z at bits [z*CNT_W +: CNT_W]. Each counter counts lookups that hit in its zone. `miss_cnt` counts lookups that miss. Both update with the response, both wrap, and both are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Clear every line |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup destination address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup found the address |
| rsp_port | output | 10 | Stored interface, 0 on a miss |
| fl_valid | input | 1 | Fill request |
| fl_addr | input | 32 | Fill address |
| fl_port | input | 10 | Fill interface number |
| fl_plen | input | 6 | Prefix length of the matched route |
| hit_cnt | output | NZ*CNT_W | Per-zone hit counters |
| miss_cnt | output | CNT_W | Global miss counter |

## Verification
A lookup and a fill can land in the same cycle, and they may name the same address or the same zone. The bench forces this in directed steps: it fills an address while looking it up, and it lets a lookup hit in a zone while a fill evicts from that zone. Random traffic from a small address pool then makes such collisions frequent. Each response is judged against a model that computes the answer from the state before the edge and only then applies the fill. In that model a fill's recency refresh takes priority over a lookup's in the same zone.

// File: rtl/zac_pkg.sv
package zac_pkg;
  localparam int ADDR_W = 32;
  localparam int PORT_W = 10;
  localparam int PLEN_W = 6;

  // zone index for a prefix length, given the ordered upper boundaries
  function automatic int zone_of(input logic [PLEN_W-1:0] plen, input int nz,
                                 input int b0, input int b1, input int b2);
    int z;
    z = 0;
    if (nz > 1 && int'(plen) > b0) z = 1;
    if (nz > 2 && int'(plen) > b1) z = 2;
    if (nz > 3 && int'(plen) > b2) z = 3;
    return z;
  endfunction

  function automatic int lines_of(input int idx, input int l0, input int l1,
                                  input int l2, input int l3);
    case (idx)
      0: return l0;
      1: return l1;
      2: return l2;
      default: return l3;
    endcase
  endfunction
endpackage

// File: rtl/zac_zone.sv
module zac_zone #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 32,
  parameter int PORT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_i,
  input  logic              lk_en_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [PORT_W-1:0] lk_port_o,
  input  logic [ADDR_W-1:0] fl_addr_i,
  input  logic [PORT_W-1:0] fl_port_i,
  output logic              fl_match_o,
  input  logic              fl_upd_i,
  input  logic              fl_new_i
);
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [IW-1:0] OLDEST = IW'(LINES - 1);

  logic [LINES-1:0]  vld;
  logic [ADDR_W-1:0] tag_q  [LINES];
  logic [PORT_W-1:0] port_q [LINES];
  logic [IW-1:0]     age_q  [LINES];

  logic [LINES-1:0]  lk_match, fl_match;
  logic [IW-1:0]     lk_idx, fl_idx, victim_idx, touch_idx;
  logic              touch_en;

  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      lk_match[i] = vld[i] && (tag_q[i] == lk_addr_i);
      fl_match[i] = vld[i] && (tag_q[i] == fl_addr_i);
      if (lk_match[i]) lk_idx = IW'(i);
      if (fl_match[i]) fl_idx = IW'(i);
    end
  end

  assign lk_hit_o   = |lk_match;
  assign lk_port_o  = lk_hit_o ? port_q[lk_idx] : '0;
  assign fl_match_o = |fl_match;

  // lowest invalid line, otherwise the oldest line
  always_comb begin
    victim_idx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (age_q[i] == OLDEST) victim_idx = IW'(i);
    for (int i = LINES - 1; i >= 0; i--)
      if (!vld[i]) victim_idx = IW'(i);
  end

  // one recency refresh per cycle; a fill outranks a lookup hit
  always_comb begin
    touch_en  = 1'b0;
    touch_idx = '0;
    if (fl_new_i) begin
      touch_en  = 1'b1;
      touch_idx = victim_idx;
    end else if (fl_upd_i) begin
      touch_en  = 1'b1;
      touch_idx = fl_idx;
    end else if (lk_en_i && lk_hit_o) begin
      touch_en  = 1'b1;
      touch_idx = lk_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        port_q[i] <= '0;
        age_q[i]  <= IW'(i);
      end
    end else begin
      if (inv_i) begin
        vld <= '0;
      end else if (fl_new_i) begin
        vld[victim_idx]    <= 1'b1;
        tag_q[victim_idx]  <= fl_addr_i;
        port_q[victim_idx] <= fl_port_i;
      end else if (fl_upd_i) begin
        port_q[fl_idx] <= fl_port_i;
      end
      if (touch_en && !inv_i) begin
        for (int j = 0; j < LINES; j++) begin
          if (IW'(j) == touch_idx) age_q[j] <= '0;
          else if (age_q[j] < age_q[touch_idx]) age_q[j] <= age_q[j] + 1'b1;
        end
      end
    end
  end

  AST_LK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R4
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fl_new_i && !inv_i |=> vld[$past(victim_idx)] &&
                           tag_q[$past(victim_idx)] == $past(fl_addr_i)); // R3
  AST_UPD_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    fl_upd_i && !inv_i |=> $countones(vld) == $countones($past(vld))); // R4
  AST_INV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |=> vld == '0); // R6
  AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en && !inv_i |=> age_q[$past(touch_idx)] == '0); // R5
endmodule

// File: rtl/zoned_addr_cache.sv
module zoned_addr_cache #(
  parameter int NZ     = 2,
  parameter int ZB0    = 22,
  parameter int ZB1    = 27,
  parameter int ZB2    = 30,
  parameter int ZL0    = 6,
  parameter int ZL1    = 3,
  parameter int ZL2    = 2,
  parameter int ZL3    = 2,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inv_all,
  input  logic                      lk_valid,
  input  logic [31:0]               lk_addr,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [9:0]                rsp_port,
  input  logic                      fl_valid,
  input  logic [31:0]               fl_addr,
  input  logic [9:0]                fl_port,
  input  logic [5:0]                fl_plen,
  output logic [NZ*CNT_W-1:0]       hit_cnt,
  output logic [CNT_W-1:0]          miss_cnt
);
  localparam int AW = zac_pkg::ADDR_W;
  localparam int PW = zac_pkg::PORT_W;

  logic [NZ-1:0] z_lk_hit, z_fl_match, z_upd, z_new;
  logic [PW-1:0] z_lk_port [NZ];
  logic          any_fl_match, any_lk_hit, fill_go;
  int            fill_zone;
  logic [PW-1:0] port_or;
  logic [CNT_W-1:0] hit_q [NZ];
  logic [CNT_W-1:0] miss_q;

  assign fill_zone    = zac_pkg::zone_of(fl_plen, NZ, ZB0, ZB1, ZB2);
  assign any_fl_match = |z_fl_match;
  assign any_lk_hit   = |z_lk_hit;
  assign fill_go      = fl_valid && !inv_all;

  for (genvar z = 0; z < NZ; z++) begin : g_zone
    assign z_upd[z] = fill_go && z_fl_match[z];
    assign z_new[z] = fill_go && !any_fl_match && (fill_zone == z);
    zac_zone #(
      .LINES (zac_pkg::lines_of(z, ZL0, ZL1, ZL2, ZL3)),
      .ADDR_W(AW),
      .PORT_W(PW)
    ) u_zone (
      .clk       (clk),
      .rst_n     (rst_n),
      .inv_i     (inv_all),
      .lk_en_i   (lk_valid),
      .lk_addr_i (lk_addr),
      .lk_hit_o  (z_lk_hit[z]),
      .lk_port_o (z_lk_port[z]),
      .fl_addr_i (fl_addr),
      .fl_port_i (fl_port),
      .fl_match_o(z_fl_match[z]),
      .fl_upd_i  (z_upd[z]),
      .fl_new_i  (z_new[z])
    );
    assign hit_cnt[z*CNT_W +: CNT_W] = hit_q[z];
  end

  always_comb begin
    port_or = '0;
    for (int z = 0; z < NZ; z++) port_or = port_or | z_lk_port[z];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_port  <= '0;
      miss_q    <= '0;
      for (int z = 0; z < NZ; z++) hit_q[z] <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_lk_hit;
      rsp_port  <= lk_valid ? port_or : '0;
      if (lk_valid && !any_lk_hit) miss_q <= miss_q + 1'b1;
      for (int z = 0; z < NZ; z++)
        if (lk_valid && z_lk_hit[z]) hit_q[z] <= hit_q[z] + 1'b1;
    end
  end

  assign miss_cnt = miss_q;

  AST_ONE_ZONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(z_lk_hit)); // R4
  AST_ONE_ZONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(z_fl_match)); // R4
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R1
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R1
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_port == '0); // R1
  AST_NEW_ONE_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(z_new) && !(|(z_new & z_upd))); // R2
  AST_PRE_FILL_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && fill_go && fl_addr == lk_addr && !any_fl_match |=>
      rsp_valid && !rsp_hit); // R7
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !any_lk_hit |=> miss_cnt == $past(miss_cnt) + 1'b1); // R8
endmodule

// File: tb/zoned_addr_cache_bench.sv
module zoned_addr_cache_bench;
  localparam int NZ = 2;
  localparam int CW = 16;
  localparam int ZL [NZ] = '{6, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv_all = 1'b0, lk_valid = 1'b0, fl_valid = 1'b0;
  logic [31:0] lk_addr = '0, fl_addr = '0;
  logic [9:0]  fl_port = '0;
  logic [5:0]  fl_plen = '0;
  logic        rsp_valid, rsp_hit;
  logic [9:0]  rsp_port;
  logic [NZ*CW-1:0] hit_cnt;
  logic [CW-1:0]    miss_cnt;

  always #5 clk = ~clk;

  zoned_addr_cache u_zoned_addr_cache (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_port(rsp_port),
    .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_port(fl_port), .fl_plen(fl_plen),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model: slot-agnostic, recency by timestamps
  bit          m_vld  [NZ][8];
  logic [31:0] m_tag  [NZ][8];
  logic [9:0]  m_port [NZ][8];
  int          m_ts   [NZ][8];
  int          now = 1;
  logic [CW-1:0] e_hit [NZ];
  logic [CW-1:0] e_miss;

  function automatic int band(input logic [5:0] plen);
    return (plen < 6'd23) ? 0 : 1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit lv, input logic [31:0] la,
                      input bit fv, input logic [31:0] fa, input logic [9:0] fp,
                      input logic [5:0] fpl, input bit iv);
    bit e_h;
    logic [9:0] e_p;
    int hz, hi, fz, fi;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; fl_valid = fv; fl_addr = fa;
    fl_port = fp; fl_plen = fpl; inv_all = iv;
    e_h = 1'b0; e_p = '0; hz = -1; hi = -1; fz = -1;
    for (int z = 0; z < NZ; z++)
      for (int i = 0; i < ZL[z]; i++)
        if (m_vld[z][i] && m_tag[z][i] == la) begin hz = z; hi = i; end
    if (lv) begin
      if (hz >= 0) begin e_h = 1'b1; e_p = m_port[hz][hi]; e_hit[hz]++; end
      else e_miss++;
    end
    if (iv) begin
      for (int z = 0; z < NZ; z++)
        for (int i = 0; i < 8; i++) m_vld[z][i] = 1'b0;
    end else if (fv) begin
      fi = -1;
      for (int z = 0; z < NZ; z++)
        for (int i = 0; i < ZL[z]; i++)
          if (m_vld[z][i] && m_tag[z][i] == fa) begin fz = z; fi = i; end
      if (fi >= 0) begin
        m_port[fz][fi] = fp; m_ts[fz][fi] = now;
      end else begin
        fz = band(fpl);
        for (int i = ZL[fz] - 1; i >= 0; i--) if (!m_vld[fz][i]) fi = i;
        if (fi < 0) begin
          fi = 0;
          for (int i = 1; i < ZL[fz]; i++) if (m_ts[fz][i] < m_ts[fz][fi]) fi = i;
        end
        m_vld[fz][fi] = 1'b1; m_tag[fz][fi] = fa; m_port[fz][fi] = fp; m_ts[fz][fi] = now;
      end
    end
    if (lv && hz >= 0 && !iv && hz != fz) m_ts[hz][hi] = now;
    now++;
    @(posedge clk); #1;
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'(lv));
    if (lv) begin
      chk({tag, " rsp_hit"}, 64'(rsp_hit), 64'(e_h));
      chk({tag, " rsp_port"}, 64'(rsp_port), 64'(e_p));
    end
    for (int z = 0; z < NZ; z++)
      chk("R8 hit_cnt", 64'(hit_cnt[z*CW +: CW]), 64'(e_hit[z]));
    chk("R8 miss_cnt", 64'(miss_cnt), 64'(e_miss));
  endtask

  function automatic logic [31:0] pool(input int k);
    return 32'hC0A8_0001 + (32'(k) << 8);
  endfunction

  initial begin
    for (int z = 0; z < NZ; z++) begin
      e_hit[z] = '0;
      for (int i = 0; i < 8; i++) begin
        m_vld[z][i] = 1'b0; m_tag[z][i] = '0; m_port[z][i] = '0; m_ts[z][i] = 0;
      end
    end
    e_miss = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R8 reset hit_cnt", 64'(hit_cnt), 64'd0);
    chk("R8 reset miss_cnt", 64'(miss_cnt), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R6: empty after reset
    step("R6 empty", 1, pool(1), 0, 0, 0, 0, 0);
    // R7: fill and lookup of the same address in one cycle
    step("R7 same cycle", 1, pool(1), 1, pool(1), 10'd5, 6'd22, 0);
    step("R1 R2 hit zone0", 1, pool(1), 0, 0, 0, 0, 0);
    step("R2 fill len23", 0, 0, 1, pool(2), 10'd9, 6'd23, 0);
    step("R2 hit zone1", 1, pool(2), 0, 0, 0, 0, 0);
    // R4: rewrite in place, prefix length ignored
    step("R4 rewrite", 0, 0, 1, pool(1), 10'd7, 6'd30, 0);
    step("R4 new port", 1, pool(1), 0, 0, 0, 0, 0);
    // R5: LRU in zone 1 (3 lines)
    step("R5 fill", 0, 0, 1, pool(3), 10'd11, 6'd32, 0);
    step("R5 fill", 0, 0, 1, pool(4), 10'd12, 6'd40, 0);
    step("R5 refresh", 1, pool(2), 0, 0, 0, 0, 0);
    step("R5 evict", 0, 0, 1, pool(5), 10'd13, 6'd25, 0);
    step("R5 evicted gone", 1, pool(3), 0, 0, 0, 0, 0);
    step("R5 kept", 1, pool(2), 0, 0, 0, 0, 0);
    // R5: lookup hit and fill in the same zone, fill wins
    step("R5 collide", 1, pool(4), 1, pool(6), 10'd14, 6'd24, 0);
    step("R5 after collide", 1, pool(4), 0, 0, 0, 0, 0);
    // R3: fill zone 0 to capacity, all held
    for (int k = 10; k < 16; k++) step("R3 fill", 0, 0, 1, pool(k), 10'(k), 6'(k), 0);
    for (int k = 10; k < 16; k++) step("R3 held", 1, pool(k), 0, 0, 0, 0, 0);
    // R6: invalidate beats a same-cycle fill
    step("R6 inv", 1, pool(10), 1, pool(20), 10'd3, 6'd8, 1);
    step("R6 cleared", 1, pool(10), 0, 0, 0, 0, 0);
    step("R6 fill dropped", 1, pool(20), 0, 0, 0, 0, 0);

    // random traffic with a fixed seed
    void'($urandom(32'd1717));
    for (int n = 0; n < 4000; n++) begin
      bit lv, fv, iv;
      logic [31:0] la, fa;
      lv = ($urandom % 10) < 7;
      fv = ($urandom % 10) < 4;
      iv = ($urandom % 250) == 0;
      la = pool(int'($urandom % 14));
      fa = pool(int'($urandom % 14));
      step("R1 R2 R4 R5 R7 random", lv, la, fv, fa, 10'($urandom),
           6'($urandom % 41), iv);
    end
    @(negedge clk);
    lk_valid = 0; fl_valid = 0; inv_all = 0;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule